// File: doc/BRIEF.md
# Dual-Edge Loadable Up/Down Counter

A binary counter, `W` bits wide (4 by default), that advances on both the rising and the falling edge of its clock. Each edge adds or subtracts one under a clock enable and a direction select, and the count wraps modulo 2^W in both directions. A synchronous parallel load acts only on rising edges and takes effect whether or not the enable is high. An active-low asynchronous clear zeroes the count and both flags.

A terminal-count flag marks the last value before a wrap in the selected direction. An enable-out, which is that flag ANDed with the enable-in, lets stages be chained into a wider counter. In a chain, clock, direction, load and clear are shared by all stages, and each stage takes its enable-in from the enable-out of the stage below it. No dual-edge flip-flop is needed. The count is the XOR of a rising-edge register and a falling-edge register, and at each edge the active register stores the next count XORed with the other register's value.

Top module: `dedge_updown_counter`

## Requirements
- R1: While `rst_ni` is low, `cnt_o`, `tc_o` and `ceo_o` are all 0 at once, whatever the clock and the other inputs do. This also sets the state after power-up.
- R2: At a rising clock edge with `ld_i` = 1, `cnt_o` takes the value of `d_i`, with `ce_i` either 0 or 1.
- R3: With `ce_i` = 1 and no load, every clock edge (rising or falling) adds 1 to `cnt_o` when `up_i` = 1 and subtracts 1 when `up_i` = 0. All-ones wraps to zero and zero wraps to all-ones.
- R4: With `ce_i` = 0 and no rising-edge load, `cnt_o` keeps its value across both clock edges.
- R5: At a falling clock edge `ld_i` and `d_i` have no effect, and only the enable and direction rules of R3/R4 apply.
- R6: `tc_o` is 1 exactly when `up_i` = 1 and `cnt_o` is all ones, or when `up_i` = 0 and `cnt_o` is all zeros. `tc_o` is 0 during clear.
- R7: `ceo_o` equals `tc_o` AND `ce_i`.
- R8: Two 4-bit stages, with the upper stage's `ce_i` driven by the lower stage's `ceo_o` and the other inputs shared, behave as one 8-bit dual-edge counter. The upper stage's `ceo_o` is the 8-bit terminal count ANDed with the shared enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both edges are active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| ld_i | input | 1 | Parallel load enable, sampled on rising edges |
| d_i | input | W | Parallel load data |
| ce_i | input | 1 | Count enable / cascade enable-in |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_o | output | W | Current count |
| tc_o | output | 1 | Terminal count for the selected direction |
| ceo_o | output | 1 | Cascade enable-out |

## Verification
Free-running sweeps of more than one full period up and then down expose the wrap at all-ones and at all-zeros on both edge types, and a count that moves on only one edge type. Loading every code with the enable alternately low and high separates the load path from the counting path. Placing the load on a falling edge, with the enable both low and high, catches a load that leaks into the falling-edge register. A clear pulse placed between edges, and an 8-bit two-stage chain loaded just below and just above its wrap points, test the flag gating and the carry and borrow between stages.

// File: rtl/dedge_pkg.sv
package dedge_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/dedge_next.sv
module dedge_next #(
  parameter int unsigned     W    = 4,
  parameter dedge_pkg::edge_e EDGE = dedge_pkg::EDGE_RISE
) (
  input  logic [W-1:0] cnt_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         ce_i,
  input  logic         up_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] step;

  always_comb begin
    if (!ce_i)     step = cnt_i;
    else if (up_i) step = cnt_i + 1'b1;
    else           step = cnt_i - 1'b1;
  end

  generate
    if (EDGE == dedge_pkg::EDGE_RISE) begin : g_rise
      assign nxt_o = ld_i ? d_i : step;
    end else begin : g_fall
      logic unused_ld;
      assign unused_ld = ld_i ^ (^d_i);
      assign nxt_o = step;
    end
  endgenerate
endmodule

// File: rtl/dedge_half_reg.sv
module dedge_half_reg #(
  parameter int unsigned     W    = 4,
  parameter dedge_pkg::edge_e EDGE = dedge_pkg::EDGE_RISE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] other_i,
  output logic [W-1:0] q_o
);
  // store nxt ^ other so that q_rise ^ q_fall == nxt after this edge
  generate
    if (EDGE == dedge_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= nxt_i ^ other_i;
      end
    end else begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= nxt_i ^ other_i;
      end
    end
  endgenerate
endmodule

// File: rtl/dedge_term.sv
module dedge_term #(
  parameter int unsigned W = 4
) (
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic         ce_i,
  output logic         tc_o,
  output logic         ceo_o
);
  logic all_one, all_zero;

  assign all_one  = &cnt_i;
  assign all_zero = ~|cnt_i;
  // gate with clear: all-zero count while down-selected must not flag
  assign tc_o  = rst_ni & (up_i ? all_one : all_zero);
  assign ceo_o = tc_o & ce_i;
endmodule

// File: rtl/dedge_updown_counter.sv
module dedge_updown_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  input  logic         ce_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o,
  output logic         ceo_o
);
  logic [W-1:0] q_rise, q_fall, nxt_rise, nxt_fall, cnt;

  assign cnt   = q_rise ^ q_fall;
  assign cnt_o = cnt;

  dedge_next #(.W(W), .EDGE(dedge_pkg::EDGE_RISE)) u_nxt_rise (
    .cnt_i(cnt), .ld_i(ld_i), .d_i(d_i), .ce_i(ce_i), .up_i(up_i), .nxt_o(nxt_rise)
  );

  dedge_next #(.W(W), .EDGE(dedge_pkg::EDGE_FALL)) u_nxt_fall (
    .cnt_i(cnt), .ld_i(ld_i), .d_i(d_i), .ce_i(ce_i), .up_i(up_i), .nxt_o(nxt_fall)
  );

  dedge_half_reg #(.W(W), .EDGE(dedge_pkg::EDGE_RISE)) u_reg_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_i(nxt_rise), .other_i(q_fall), .q_o(q_rise)
  );

  dedge_half_reg #(.W(W), .EDGE(dedge_pkg::EDGE_FALL)) u_reg_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_i(nxt_fall), .other_i(q_rise), .q_o(q_fall)
  );

  dedge_term #(.W(W)) u_term (
    .rst_ni(rst_ni), .cnt_i(cnt), .up_i(up_i), .ce_i(ce_i), .tc_o(tc_o), .ceo_o(ceo_o)
  );
endmodule

// File: rtl/dedge_updown_counter_chk.sv
module dedge_updown_counter_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ld_i,
  input logic [W-1:0] d_i,
  input logic         ce_i,
  input logic         up_i,
  input logic [W-1:0] cnt_o,
  input logic         tc_o,
  input logic         ceo_o
);
  // inputs and count seen at the last rising edge, checked at the next falling edge
  logic         r_vld, r_ld, r_ce, r_up;
  logic [W-1:0] r_d, r_cnt;
  // same for the last falling edge, checked at the next rising edge
  logic         f_vld, f_ce, f_up;
  logic [W-1:0] f_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_vld <= 1'b0; r_ld <= 1'b0; r_ce <= 1'b0; r_up <= 1'b0;
      r_d   <= '0;   r_cnt <= '0;
    end else begin
      r_vld <= 1'b1; r_ld <= ld_i; r_ce <= ce_i; r_up <= up_i;
      r_d   <= d_i;  r_cnt <= cnt_o;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_vld <= 1'b0; f_ce <= 1'b0; f_up <= 1'b0; f_cnt <= '0;
    end else begin
      f_vld <= 1'b1; f_ce <= ce_i; f_up <= up_i; f_cnt <= cnt_o;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_o == '0 && !tc_o && !ceo_o));

  // R2
  rise_load_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (r_vld && r_ld) |-> cnt_o == r_d);

  // R3
  rise_count_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (r_vld && !r_ld && r_ce) |-> cnt_o == (r_up ? r_cnt + 1'b1 : r_cnt - 1'b1));

  // R3
  fall_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_vld && f_ce) |-> cnt_o == (f_up ? f_cnt + 1'b1 : f_cnt - 1'b1));

  // R4
  rise_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (r_vld && !r_ld && !r_ce) |-> cnt_o == r_cnt);

  // R5
  fall_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_vld && !f_ce) |-> cnt_o == f_cnt);

  // R6
  tc_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> ((up_i && cnt_o == '1) || (!up_i && cnt_o == '0)));

  // R7
  ceo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ceo_o |-> (tc_o && ce_i));
endmodule

bind dedge_updown_counter dedge_updown_counter_chk #(.W(W)) u_chk (.*);

// File: tb/dedge_updown_counter_bench.sv
`timescale 1ns/100ps
module dedge_updown_counter_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ld = 1'b0, ce = 1'b0, up = 1'b1;
  logic [W-1:0] d = '0;
  logic [7:0]   d8 = '0;
  logic [W-1:0] cnt, lo_cnt, hi_cnt;
  logic         tc, ceo, lo_tc, lo_ceo, hi_tc, hi_ceo;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m = '0;
  logic [7:0]   m8 = '0;
  bit done = 0;

  always #2 clk = ~clk;

  dedge_updown_counter #(.W(W)) u_dedge_updown_counter (
    .clk_i(clk), .rst_ni(rst_ni), .ld_i(ld), .d_i(d), .ce_i(ce), .up_i(up),
    .cnt_o(cnt), .tc_o(tc), .ceo_o(ceo)
  );

  // R8: two-stage chain
  dedge_updown_counter #(.W(4)) u_lo (
    .clk_i(clk), .rst_ni(rst_ni), .ld_i(ld), .d_i(d8[3:0]), .ce_i(ce), .up_i(up),
    .cnt_o(lo_cnt), .tc_o(lo_tc), .ceo_o(lo_ceo)
  );
  dedge_updown_counter #(.W(4)) u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .ld_i(ld), .d_i(d8[7:4]), .ce_i(lo_ceo), .up_i(up),
    .cnt_o(hi_cnt), .tc_o(hi_tc), .ceo_o(hi_ceo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, 32'(cnt), 32'(m));
    chk("R6", 32'(tc), 32'(rst_ni && (up ? (m == '1) : (m == '0))));
    chk("R7", 32'(ceo), 32'(rst_ni && ce && (up ? (m == '1) : (m == '0))));
    chk("R8 count", 32'({hi_cnt, lo_cnt}), 32'(m8));
    chk("R8 ceo", 32'(hi_ceo), 32'(rst_ni && ce && (up ? (m8 == 8'hFF) : (m8 == 8'h00))));
  endtask

  // one clock edge; expected values from inputs held before the edge
  task automatic half(input string req);
    bit rising;
    logic [W-1:0] e;
    logic [7:0] e8;
    rising = (clk == 1'b0);
    if (rising && ld) begin
      e = d; e8 = d8;
    end else if (ce) begin
      e  = up ? m + 1'b1 : m - 1'b1;
      e8 = up ? m8 + 1'b1 : m8 - 1'b1;
    end else begin
      e = m; e8 = m8;
    end
    @(clk);
    #1;
    m = e; m8 = e8;
    check_all(req);
  endtask

  task automatic align_rise();
    if (clk == 1'b1) begin
      ld = 1'b0; ce = 1'b0;
      half("R4");
    end
  endtask

  task automatic align_fall();
    if (clk == 1'b0) begin
      ld = 1'b0; ce = 1'b0;
      half("R4");
    end
  endtask

  initial begin
    #3;
    // R1 reset state with up=0, where an ungated flag would show
    up = 1'b0; ce = 1'b1;
    #0.5;
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 ceo", 32'(ceo), 0);
    #1.5;
    rst_ni = 1'b1; m = '0; m8 = '0;
    ce = 1'b0; up = 1'b1;
    half("R4");

    // R3 up sweep past the all-ones wrap, on both edge types
    ce = 1'b1; up = 1'b1;
    for (int i = 0; i < 2 * (1 << W) + 3; i++) half("R3 up");
    // R3 down sweep past the zero wrap
    up = 1'b0;
    for (int i = 0; i < 2 * (1 << W) + 3; i++) half("R3 down");

    // R2 load every code, enable alternately low and high
    for (int v = 0; v < (1 << W); v++) begin
      align_rise();
      ld = 1'b1; d = W'(v); d8 = {4'(v), 4'(~v)}; ce = v[0]; up = v[1];
      half("R2");
      ld = 1'b0; ce = 1'b0;
      half("R4");
      half("R4");
    end

    // R5 load on falling edge ignored, enable low then high
    align_fall();
    ld = 1'b1; d = ~m; d8 = ~m8; ce = 1'b0;
    half("R5 hold");
    half("R2");
    align_fall();
    ld = 1'b1; d = ~m; d8 = ~m8; ce = 1'b1; up = 1'b1;
    half("R5 count");
    ld = 1'b0;

    // R1 clear between edges, then count down from zero
    ce = 1'b1; up = 1'b1;
    half("R3"); half("R3"); half("R3");
    rst_ni = 1'b0; up = 1'b0;
    #0.4;
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 ceo", 32'(ceo), 0);
    chk("R1 chain", 32'({hi_cnt, lo_cnt}), 0);
    #0.2;
    rst_ni = 1'b1; m = '0; m8 = '0;
    for (int i = 0; i < 4; i++) half("R3 after clear");

    // R8 chain carry near the 8-bit top and borrow near zero
    align_rise();
    ld = 1'b1; d8 = 8'hFC; d = 4'hC; up = 1'b1; ce = 1'b0;
    half("R8 load");
    ld = 1'b0; ce = 1'b1;
    for (int i = 0; i < 12; i++) half("R8 up");
    align_rise();
    ld = 1'b1; d8 = 8'h13; d = 4'h3; up = 1'b0; ce = 1'b1;
    half("R8 load");
    ld = 1'b0;
    for (int i = 0; i < 24; i++) half("R8 down");
    ce = 1'b0;
    for (int i = 0; i < 4; i++) half("R4 chain hold");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule